// File: doc/BRIEF.md
# Programmable MMIO Region Address Router

This block decodes the address of each request on the request side of a coherence manager and picks the port the request leaves on. Software can program up to eight address windows through a small register bus. Each window has a lower-bound word and an upper-bound word. The lower-bound word also carries an enable flag, a one-hot choice among four auxiliary ports and a filter on the request's cache-coherency attribute. It also holds two flags that the block only stores: one for force-non-coherent and one that disables request limiting.

An incoming request carries a 48-bit physical address and a 2-bit attribute code. It is compared against every window at once. The lowest-numbered enabled window that contains the address and accepts the attribute wins. Any request that no window claims goes to the main-memory port. The decision is registered, and the result is handed downstream through a valid/ready pair. A read-only word at offset 0x000 reports how many windows are built in.

Top module: `mmr_router`

## Requirements
- R1: After reset every window is disabled and its words read as zero, `out_valid` is low, `req_ready` is high, and every request is routed to main memory (`out_port` = 0, `out_hit` = 0, `out_region` = 0).
- R2: The lower-bound word of window n sits at offset 0x700 + n*0x10, and the upper-bound word sits at 0x708 + n*0x10. The lower-bound word keeps bits 47:16 (base), 9:8 (attribute selector), 6 (force-non-coherent), 5:2 (port one-hot), 1 (limit-disable) and 0 (enable). The upper-bound word keeps only bits 47:16. All other bits read back as zero. Read data appears on `reg_rdata` the cycle after `reg_rd_en` and holds until the next read.
- R3: A read of offset 0x000 returns the number of implemented windows in bits 7:0. Writes to that offset change nothing.
- R4: A window contains an address when base ≤ addr[47:16] ≤ limit. The upper bound is inclusive up to the last byte of its 64 KiB block.
- R5: A window whose enable bit is 0 never matches.
- R6: A request that no window claims leaves on `out_port` = 0 with `out_hit` = 0 and `out_region` = 0.
- R7: `out_port` encodes 0 = main memory and k+1 = auxiliary port k. Bit 2+k of the winning window's port field selects auxiliary port k. If several bits are set, the lowest one wins. A zero field routes to main memory with `out_hit` = 1.
- R8: When several enabled windows match, the lowest-numbered one wins and is reported on `out_region`.
- R9: Request attribute codes are 0 = uncached, 1 = uncached-accelerated, 2 = cacheable non-coherent and 3 = cacheable coherent. Selector 2'b00 accepts every code. Selectors 2'b01, 2'b10 and 2'b11 accept only codes 0 and 1. A refused attribute does not match that window.
- R10: A request accepted at a clock edge (`req_valid` and `req_ready`) appears on the outputs right after that edge. `req_ready` is high when `out_valid` is low or `out_ready` is high. Outputs hold steady while `out_valid` is high and `out_ready` is low.
- R11: A request accepted in the same cycle as a register write is routed with the window settings that were in place before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, one cycle after the strobe |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 48 | Request physical address |
| req_cca | input | 2 | Request coherency attribute code |
| out_valid | output | 1 | Routing result present |
| out_ready | input | 1 | Downstream takes the result |
| out_addr | output | 48 | Address of the routed request |
| out_port | output | 3 | 0 = main memory, k+1 = auxiliary port k |
| out_hit | output | 1 | Some window claimed the request |
| out_region | output | 3 | Index of the winning window, 0 on a miss |

## Verification
The two functions that can meet in a single cycle are a register write that reprograms a window and the acceptance of a request that falls inside that window. The bench raises both strobes at the same clock edge: it enables a window while, at that edge, it also presents an address inside it. It expects that request to reach main memory, because the write is not yet visible. It then expects the next identical request to reach the auxiliary port. A second overlap is a stalled output facing a new request. That case is judged by holding the outputs steady and then seeing the waiting request appear on the first edge with `out_ready` high.

// File: rtl/mmr_pkg.sv
package mmr_pkg;
    parameter int ADDR_W   = 48;
    parameter int GRAN_LSB = 16;
    parameter int BLK_W    = ADDR_W - GRAN_LSB;
    parameter int NUM_AUX  = 4;
    parameter int CCA_W    = 2;
    parameter int SEL_W    = 2;
    parameter int REG_AW   = 12;
    parameter int REG_DW   = 64;
    parameter int PORT_W   = $clog2(NUM_AUX + 1);

    // field positions inside the lower-bound word
    parameter int F_EN     = 0;
    parameter int F_NOLIM  = 1;
    parameter int F_PORT   = 2;
    parameter int F_FNC    = 6;
    parameter int F_SEL    = 8;

    parameter logic [CCA_W-1:0] CCA_UC  = 2'd0;
    parameter logic [CCA_W-1:0] CCA_UCA = 2'd1;
    parameter logic [SEL_W-1:0] SEL_ANY = 2'd0;

    parameter logic [REG_AW-1:0] OFS_CFG   = 12'h000;
    parameter logic [REG_AW-1:0] OFS_RGN   = 12'h700;

    typedef logic [PORT_W-1:0] port_t;

    typedef struct packed {
        logic [BLK_W-1:0]   base_blk;
        logic [BLK_W-1:0]   lim_blk;
        logic [SEL_W-1:0]   attr_sel;
        logic               force_nc;
        logic [NUM_AUX-1:0] port_oh;
        logic               no_lim;
        logic               en;
    } rgn_cfg_t;
endpackage

// File: rtl/mmr_regs.sv
module mmr_regs
    import mmr_pkg::*;
#(
    parameter int NR = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [REG_AW-1:0]         addr,
    input  logic [REG_DW-1:0]         wdata,
    output logic [REG_DW-1:0]         rdata,
    output logic [NR-1:0]             rgn_en,
    output logic [NR-1:0][BLK_W-1:0]  rgn_base,
    output logic [NR-1:0][BLK_W-1:0]  rgn_lim,
    output logic [NR-1:0][SEL_W-1:0]  rgn_sel,
    output logic [NR-1:0][NUM_AUX-1:0] rgn_port
);
    localparam int SLOT_W = 3;  // windows are spaced 0x10 apart inside a 0x80 block

    typedef struct packed {
        rgn_cfg_t [NR-1:0]   rgn;
        logic [REG_DW-1:0]   rdata;
    } regs_t;

    regs_t st_d, st_q;

    logic              in_block;
    logic [SLOT_W-1:0] slot;
    logic              upper;

    function automatic logic [REG_DW-1:0] lower_word(rgn_cfg_t c);
        logic [REG_DW-1:0] w;
        w = '0;
        w[ADDR_W-1:GRAN_LSB]   = c.base_blk;
        w[F_SEL +: SEL_W]      = c.attr_sel;
        w[F_FNC]               = c.force_nc;
        w[F_PORT +: NUM_AUX]   = c.port_oh;
        w[F_NOLIM]             = c.no_lim;
        w[F_EN]                = c.en;
        return w;
    endfunction

    always_comb begin
        in_block = (addr[REG_AW-1:7] == OFS_RGN[REG_AW-1:7]) && (addr[2:0] == 3'd0);
        slot     = addr[6:4];
        upper    = addr[3];
        st_d     = st_q;

        for (int r = 0; r < NR; r++) begin
            if (wr_en && in_block && slot == SLOT_W'(r)) begin
                if (upper) begin
                    st_d.rgn[r].lim_blk = wdata[ADDR_W-1:GRAN_LSB];
                end else begin
                    st_d.rgn[r].base_blk = wdata[ADDR_W-1:GRAN_LSB];
                    st_d.rgn[r].attr_sel = wdata[F_SEL +: SEL_W];
                    st_d.rgn[r].force_nc = wdata[F_FNC];
                    st_d.rgn[r].port_oh  = wdata[F_PORT +: NUM_AUX];
                    st_d.rgn[r].no_lim   = wdata[F_NOLIM];
                    st_d.rgn[r].en       = wdata[F_EN];
                end
            end
        end

        if (rd_en) begin
            st_d.rdata = '0;
            if (addr == OFS_CFG) begin
                st_d.rdata[7:0] = 8'(NR);
            end
            for (int r = 0; r < NR; r++) begin
                if (in_block && slot == SLOT_W'(r)) begin
                    if (upper) begin
                        st_d.rdata[ADDR_W-1:GRAN_LSB] = st_q.rgn[r].lim_blk;
                    end else begin
                        st_d.rdata = lower_word(st_q.rgn[r]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

    for (genvar r = 0; r < NR; r++) begin : g_out
        assign rgn_en[r]   = st_q.rgn[r].en;
        assign rgn_base[r] = st_q.rgn[r].base_blk;
        assign rgn_lim[r]  = st_q.rgn[r].lim_blk;
        assign rgn_sel[r]  = st_q.rgn[r].attr_sel;
        assign rgn_port[r] = st_q.rgn[r].port_oh;
    end
endmodule

// File: rtl/mmr_region_match.sv
module mmr_region_match
    import mmr_pkg::*;
(
    input  logic             en,
    input  logic [BLK_W-1:0] base_blk,
    input  logic [BLK_W-1:0] lim_blk,
    input  logic [SEL_W-1:0] attr_sel,
    input  logic [BLK_W-1:0] req_blk,
    input  logic [CCA_W-1:0] req_cca,
    output logic             hit
);
    logic in_range;
    logic attr_ok;

    always_comb begin
        in_range = (req_blk >= base_blk) && (req_blk <= lim_blk);
        attr_ok  = (attr_sel == SEL_ANY) || (req_cca == CCA_UC) || (req_cca == CCA_UCA);
        hit      = en && in_range && attr_ok;
    end
endmodule

// File: rtl/mmr_router.sv
module mmr_router
    import mmr_pkg::*;
#(
    parameter int NR = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [11:0]       reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [47:0]       req_addr,
    input  logic [1:0]        req_cca,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [47:0]       out_addr,
    output logic [2:0]        out_port,
    output logic              out_hit,
    output logic [2:0]        out_region
);
    localparam int IDX_W = (NR > 1) ? $clog2(NR) : 1;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        port_t             port;
        logic              hit;
        logic [IDX_W-1:0]  region;
    } out_t;

    logic [NR-1:0]              rgn_en;
    logic [NR-1:0][BLK_W-1:0]   rgn_base;
    logic [NR-1:0][BLK_W-1:0]   rgn_lim;
    logic [NR-1:0][SEL_W-1:0]   rgn_sel;
    logic [NR-1:0][NUM_AUX-1:0] rgn_port;
    logic [NR-1:0]              hits;

    logic              any_hit;
    logic [IDX_W-1:0]  win_idx;
    port_t             win_port;
    out_t              o_d, o_q;

    mmr_regs #(.NR(NR)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .rgn_en   (rgn_en),
        .rgn_base (rgn_base),
        .rgn_lim  (rgn_lim),
        .rgn_sel  (rgn_sel),
        .rgn_port (rgn_port)
    );

    for (genvar r = 0; r < NR; r++) begin : g_match
        mmr_region_match u_match (
            .en       (rgn_en[r]),
            .base_blk (rgn_base[r]),
            .lim_blk  (rgn_lim[r]),
            .attr_sel (rgn_sel[r]),
            .req_blk  (req_addr[ADDR_W-1:GRAN_LSB]),
            .req_cca  (req_cca),
            .hit      (hits[r])
        );
    end

    // lowest index wins; scan from the top so the last assignment is the lowest
    always_comb begin
        any_hit  = 1'b0;
        win_idx  = '0;
        win_port = '0;
        for (int r = NR - 1; r >= 0; r--) begin
            if (hits[r]) begin
                any_hit  = 1'b1;
                win_idx  = IDX_W'(r);
                win_port = '0;
                for (int k = NUM_AUX - 1; k >= 0; k--) begin
                    if (rgn_port[r][k]) begin
                        win_port = port_t'(k + 1);
                    end
                end
            end
        end
    end

    assign req_ready = !o_q.valid || out_ready;

    always_comb begin
        o_d = o_q;
        if (out_ready) begin
            o_d.valid = 1'b0;
        end
        if (req_valid && req_ready) begin
            o_d.valid  = 1'b1;
            o_d.addr   = req_addr;
            o_d.port   = win_port;
            o_d.hit    = any_hit;
            o_d.region = win_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid  = o_q.valid;
    assign out_addr   = o_q.addr;
    assign out_port   = o_q.port;
    assign out_hit    = o_q.hit;
    assign out_region = o_q.region;
endmodule

// File: rtl/mmr_router_chk.sv
module mmr_router_chk #(
    parameter int NR = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_rd_en,
    input logic [11:0] reg_addr,
    input logic [63:0] reg_rdata,
    input logic        req_valid,
    input logic        req_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [47:0] out_addr,
    input logic [2:0]  out_port,
    input logic        out_hit,
    input logic [2:0]  out_region
);
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_port)
                                    && $stable(out_hit) && $stable(out_region));

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && !req_valid |=> !out_valid);

    p_miss_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_hit |-> out_port == 3'd0 && out_region == 3'd0);

    p_cfg_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en && reg_addr == 12'h000 |=> reg_rdata == 64'(NR));
endmodule

bind mmr_router mmr_router_chk #(.NR(NR)) u_chk (.*);

// File: tb/sim_mmr_router.sv
module sim_mmr_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic        req_valid = 1'b0, req_ready;
    logic [47:0] req_addr = '0, out_addr;
    logic [1:0]  req_cca = '0;
    logic        out_valid, out_ready = 1'b1, out_hit;
    logic [2:0]  out_port, out_region;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    mmr_router u0 (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    // route check: packed {port, hit, region}
    task automatic route(input string tag, input logic [47:0] a, input logic [1:0] c,
                         input logic [2:0] ep, input logic eh, input logic [2:0] er);
        @(negedge clk);
        out_ready = 1'b1; req_valid = 1'b1; req_addr = a; req_cca = c;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 64'(out_valid), 64'd1);
        check({tag, " route"}, 64'({out_port, out_hit, out_region}), 64'({ep, eh, er}));
    endtask

    task automatic t_reset();
        logic [63:0] d;
        check("R1 out_valid", 64'(out_valid), 64'd0);
        check("R1 req_ready", 64'(req_ready), 64'd1);
        rd(12'h700, d);
        check("R1 bottom0 zero", d, 64'd0);
        route("R1 default route", 48'h2000_0000, 2'd3, 3'd0, 1'b0, 3'd0);
    endtask

    task automatic t_regs();
        logic [63:0] d;
        wr(12'h710, 64'hFFFF_1234_5678_03FF);
        rd(12'h710, d);
        check("R2 bottom1 readback", d, 64'h0000_1234_5678_037F);
        wr(12'h718, 64'h0000_0000_677F_FFFF);
        rd(12'h718, d);
        check("R2 top1 readback", d, 64'h0000_0000_677F_0000);
        wr(12'h710, 64'd0);
        rd(12'h710, d);
        check("R2 bottom1 cleared", d, 64'd0);
    endtask

    task automatic t_cfg();
        logic [63:0] d;
        rd(12'h000, d);
        check("R3 region count", d, 64'd8);
        wr(12'h000, 64'hFF);
        rd(12'h000, d);
        check("R3 count read-only", d, 64'd8);
    endtask

    task automatic t_range();
        wr(12'h700, 64'h2000_0005);            // aux0, any attribute, enabled
        wr(12'h708, 64'h677F_FFFF);
        route("R4 top inclusive", 48'h677F_FFFF, 2'd3, 3'd1, 1'b1, 3'd0);
        route("R4 above top", 48'h6780_0000, 2'd3, 3'd0, 1'b0, 3'd0);
        route("R4 at base", 48'h2000_0000, 2'd2, 3'd1, 1'b1, 3'd0);
        route("R6 below base", 48'h1FFF_FFFF, 2'd0, 3'd0, 1'b0, 3'd0);
    endtask

    task automatic t_hold();
        @(negedge clk);
        out_ready = 1'b0; req_valid = 1'b1; req_addr = 48'h3000_0000; req_cca = 2'd3;
        @(negedge clk);
        check("R10 valid after accept", 64'(out_valid), 64'd1);
        check("R10 ready low when stalled", 64'(req_ready), 64'd0);
        req_addr = 48'h0000_1000;
        repeat (2) @(negedge clk);
        check("R10 held route", 64'({out_port, out_hit, out_region}), 64'({3'd1, 1'b1, 3'd0}));
        check("R10 held addr", 64'(out_addr), 64'h3000_0000);
        out_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 second addr", 64'(out_addr), 64'h0000_1000);
        check("R10 second route", 64'({out_port, out_hit, out_region}), 64'd0);
        @(negedge clk);
        check("R10 drained", 64'(out_valid), 64'd0);
    endtask

    task automatic t_disable();
        wr(12'h700, 64'h2000_0004);            // same window, enable cleared
        route("R5 disabled window", 48'h3000_0000, 2'd3, 3'd0, 1'b0, 3'd0);
    endtask

    task automatic t_attr();
        wr(12'h720, 64'h8000_0109);            // aux1, uncached only
        wr(12'h728, 64'h1F_FFFF_FFFF);
        route("R9 uc accepted", 48'h9000_0000, 2'd0, 3'd2, 1'b1, 3'd2);
        route("R9 uca accepted", 48'h9000_0000, 2'd1, 3'd2, 1'b1, 3'd2);
        route("R9 coherent refused", 48'h9000_0000, 2'd3, 3'd0, 1'b0, 3'd0);
        wr(12'h720, 64'h8000_0209);            // reserved selector acts as uncached only
        route("R9 reserved sel refuses", 48'h9000_0000, 2'd2, 3'd0, 1'b0, 3'd0);
        route("R9 reserved sel accepts", 48'h9000_0000, 2'd1, 3'd2, 1'b1, 3'd2);
    endtask

    task automatic t_port();
        wr(12'h738, 64'h30_0000_FFFF);
        wr(12'h730, 64'h30_0000_0031);         // bits 5:4 set
        route("R7 lowest port bit", 48'h30_0000_8000, 2'd3, 3'd3, 1'b1, 3'd3);
        wr(12'h730, 64'h30_0000_0021);
        route("R7 aux3", 48'h30_0000_8000, 2'd3, 3'd4, 1'b1, 3'd3);
        wr(12'h730, 64'h30_0000_0001);
        route("R7 empty field to mem", 48'h30_0000_8000, 2'd3, 3'd0, 1'b1, 3'd3);
    endtask

    task automatic t_prio();
        wr(12'h748, 64'h30_0000_FFFF);
        wr(12'h740, 64'h30_0000_0005);         // window 4, aux0
        wr(12'h730, 64'h30_0000_0009);         // window 3, aux1
        route("R8 lower index wins", 48'h30_0000_0000, 2'd3, 3'd2, 1'b1, 3'd3);
        wr(12'h730, 64'h30_0000_0008);
        route("R8 next window", 48'h30_0000_0000, 2'd3, 3'd1, 1'b1, 3'd4);
    endtask

    task automatic t_same();
        wr(12'h758, 64'h40_0000_FFFF);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 12'h750; reg_wdata = 64'h40_0000_0005;
        out_ready = 1'b1; req_valid = 1'b1; req_addr = 48'h40_0000_1000; req_cca = 2'd3;
        @(negedge clk);
        reg_wr_en = 1'b0; req_valid = 1'b0;
        check("R11 old config used", 64'({out_valid, out_port, out_hit, out_region}),
              64'({1'b1, 3'd0, 1'b0, 3'd0}));
        route("R11 new config next", 48'h40_0000_1000, 2'd3, 3'd1, 1'b1, 3'd5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_cfg();
        t_range();
        t_hold();
        t_disable();
        t_attr();
        t_port();
        t_prio();
        t_same();
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule